// File: doc/BRIEF.md
# Software Write-Protection Guard

This block sits in front of a byte-wide nonvolatile array model. It watches every qualified byte-load, an address and data pair presented with `load_valid`, and decides whether that load may change the array. It keeps a single global protection flag covering the whole array. The flag is clear after reset. A three-load unlock prefix authorises exactly one following load. The same prefix also switches global protection on if it was off. A separate six-load command switches protection off again.

While protection is on, any load that arrives without the prefix is refused. A refused load opens a lockout window of `LOCK_CYCLES` clock cycles. During the window the guard discards every load. The default window is sized for roughly 300 µs at a 125 MHz clock. Command loads that the matcher consumes are never passed on as array writes.

Top module: `swp_guard`

## Requirements
- R1: Reset, which is asynchronous, clears protection, ends any lockout, drops `write_allow` and returns the matcher to idle. After release, an A0h load at address 5555h is handled as a plain load.
- R2: While unprotected, a load that is not consumed as a command raises `write_allow` for exactly the one cycle after the clock edge that sampled it.
- R3: The unlock prefix is AAh at 5555h, then 55h at 2AAAh, then A0h at 5555h, on consecutive qualified loads. Completing it sets `prot_on` from the next cycle. Loads consumed as sequence codes never raise `write_allow`.
- R4: The first qualified load after a completed prefix raises `write_allow` for one cycle, at any address and with any data, whether protection was already on or not.
- R5: While protected, a load that is not authorised by a prefix gives no `write_allow`. `lockout` then rises in the next cycle and stays high for exactly `LOCK_CYCLES` cycles.
- R6: The six-load disarm command clears `prot_on` from the next cycle and raises no `write_allow`. The command is AAh at 5555h, 55h at 2AAAh, 80h at 5555h, AAh at 5555h, 55h at 2AAAh, 20h at 5555h.
- R7: A load that breaks a sequence part-way returns the matcher to idle, and does so even when that load carries a first code. While protected, such a load is refused and starts a lockout. While unprotected, it is an ordinary load that gets `write_allow`.
- R8: Loads that arrive while `lockout` is high are discarded. They raise no `write_allow`, leave `prot_on` unchanged and do not advance the matcher.
- R9: One prefix authorises only one load. A second load right after an authorised one, while protected, is refused.
- R10: A cycle with `load_valid` low changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously, released through a two-stage synchroniser |
| load_valid | input | 1 | Qualifies a byte-load this cycle |
| load_addr | input | ADDR_W | Address of the byte-load |
| load_data | input | DATA_W | Data of the byte-load |
| write_allow | output | 1 | One-cycle pulse: the sampled load may alter the array |
| prot_on | output | 1 | Global protection flag |
| lockout | output | 1 | High while the guard discards loads after a refused write |

## Verification
The hardest situation to reach is a full command arriving inside a lockout window. The design must throw it away without leaving the matcher part-way through a sequence. The stimulus refuses one load to open the window. It then feeds the whole disarm command and the whole unlock prefix while `lockout` is high, and counts the window length. Once the window closes, it sends a single bare load. A second refusal, with protection still on, shows that nothing from inside the window was kept. A reset in the middle of a prefix is checked the same way: the code that would have completed the prefix is sent after release.

// File: rtl/swp_pkg.sv
package swp_pkg;

  localparam int CODE_N = 5;
  localparam int CI_AA  = 0;
  localparam int CI_55  = 1;
  localparam int CI_A0  = 2;
  localparam int CI_80  = 3;
  localparam int CI_20  = 4;

  localparam logic [14:0] ADR_ODD  = 15'h5555;
  localparam logic [14:0] ADR_EVEN = 15'h2AAA;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_C1,
    SQ_C2,
    SQ_ARMED,
    SQ_D3,
    SQ_D4,
    SQ_D5
  } sq_state_t;

  typedef enum logic [2:0] {
    EV_NONE,
    EV_CMD,
    EV_ARM,
    EV_DISARM,
    EV_AUTH,
    EV_STRAY
  } sq_event_t;

  function automatic logic [14:0] code_addr(input int idx);
    case (idx)
      CI_55:   return ADR_EVEN;
      default: return ADR_ODD;
    endcase
  endfunction

  function automatic logic [7:0] code_data(input int idx);
    case (idx)
      CI_AA:   return 8'hAA;
      CI_55:   return 8'h55;
      CI_A0:   return 8'hA0;
      CI_80:   return 8'h80;
      default: return 8'h20;
    endcase
  endfunction

endpackage

// File: rtl/swp_code_cmp.sv
module swp_code_cmp
  import swp_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic [CODE_N-1:0] hit
);

  // One address/data comparator per command code.
  for (genvar gi = 0; gi < CODE_N; gi++) begin : g_code
    localparam logic [ADDR_W-1:0] CODE_A = ADDR_W'(code_addr(gi));
    localparam logic [DATA_W-1:0] CODE_D = DATA_W'(code_data(gi));
    assign hit[gi] = (addr == CODE_A) && (data == CODE_D);
  end

endmodule

// File: rtl/swp_seq_fsm.sv
module swp_seq_fsm
  import swp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic [CODE_N-1:0] hit,
  output sq_event_t         ev
);

  sq_state_t state_q;
  sq_state_t state_d;

  // Next state and event for the load being sampled.
  always_comb begin
    state_d = state_q;
    ev      = EV_NONE;
    if (step_en) begin
      state_d = SQ_IDLE;
      ev      = EV_STRAY;
      unique case (state_q)
        SQ_IDLE: begin
          if (hit[CI_AA]) begin
            state_d = SQ_C1;
            ev      = EV_CMD;
          end
        end
        SQ_C1: begin
          if (hit[CI_55]) begin
            state_d = SQ_C2;
            ev      = EV_CMD;
          end
        end
        SQ_C2: begin
          if (hit[CI_A0]) begin
            state_d = SQ_ARMED;
            ev      = EV_ARM;
          end else if (hit[CI_80]) begin
            state_d = SQ_D3;
            ev      = EV_CMD;
          end
        end
        SQ_ARMED: begin
          ev = EV_AUTH;
        end
        SQ_D3: begin
          if (hit[CI_AA]) begin
            state_d = SQ_D4;
            ev      = EV_CMD;
          end
        end
        SQ_D4: begin
          if (hit[CI_55]) begin
            state_d = SQ_D5;
            ev      = EV_CMD;
          end
        end
        SQ_D5: begin
          if (hit[CI_20]) begin
            ev = EV_DISARM;
          end
        end
        default: begin
          state_d = SQ_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
    end else if (step_en) begin
      state_q <= state_d;
    end
  end

endmodule

// File: rtl/swp_lock_timer.sv
module swp_lock_timer #(
  parameter int LOCK_CYCLES = 37500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic locked
);

  localparam int CW = $clog2(LOCK_CYCLES + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          lock_q;
  logic          lock_d;
  logic          upd_en;

  always_comb begin
    cnt_d  = cnt_q;
    lock_d = lock_q;
    if (start) begin
      cnt_d  = CW'(LOCK_CYCLES - 1);
      lock_d = 1'b1;
    end else if (lock_q) begin
      if (cnt_q == '0) begin
        lock_d = 1'b0;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  assign upd_en = start | lock_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      lock_q <= 1'b0;
    end else if (upd_en) begin
      cnt_q  <= cnt_d;
      lock_q <= lock_d;
    end
  end

  assign locked = lock_q;

endmodule

// File: rtl/swp_guard.sv
module swp_guard
  import swp_pkg::*;
#(
  parameter int ADDR_W      = 15,
  parameter int DATA_W      = 8,
  parameter int LOCK_CYCLES = 37500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_valid,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [DATA_W-1:0] load_data,
  output logic              write_allow,
  output logic              prot_on,
  output logic              lockout
);

  // Reset: asynchronous assertion, synchronous release.
  logic [1:0] rst_pipe_q;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end

  assign srst_n = rst_pipe_q[1];

  logic [CODE_N-1:0] hit;
  sq_event_t         ev;
  logic              step_en;
  logic              start_lock;
  logic              allow_d;
  logic              allow_q;
  logic              prot_d;
  logic              prot_q;
  logic              prot_en;

  assign step_en = load_valid & ~lockout;

  swp_code_cmp #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_cmp (
    .addr (load_addr),
    .data (load_data),
    .hit  (hit)
  );

  swp_seq_fsm u_fsm (
    .clk     (clk),
    .rst_n   (srst_n),
    .step_en (step_en),
    .hit     (hit),
    .ev      (ev)
  );

  // Decision for the sampled load.
  always_comb begin
    allow_d    = 1'b0;
    start_lock = 1'b0;
    prot_d     = prot_q;
    prot_en    = 1'b0;
    case (ev)
      EV_AUTH:   allow_d = 1'b1;
      EV_STRAY: begin
        allow_d    = ~prot_q;
        start_lock = prot_q;
      end
      EV_ARM: begin
        prot_d  = 1'b1;
        prot_en = 1'b1;
      end
      EV_DISARM: begin
        prot_d  = 1'b0;
        prot_en = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      allow_q <= 1'b0;
    end else begin
      allow_q <= allow_d;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      prot_q <= 1'b0;
    end else if (prot_en) begin
      prot_q <= prot_d;
    end
  end

  swp_lock_timer #(
    .LOCK_CYCLES (LOCK_CYCLES)
  ) u_lock (
    .clk    (clk),
    .rst_n  (srst_n),
    .start  (start_lock),
    .locked (lockout)
  );

  assign write_allow = allow_q;
  assign prot_on     = prot_q;

endmodule

// File: rtl/swp_guard_chk.sv
module swp_guard_chk #(
  parameter int LOCK_CYCLES = 37500
) (
  input logic clk,
  input logic rst_n,
  input logic load_valid,
  input logic write_allow,
  input logic prot_on,
  input logic lockout
);

  localparam int RW = $clog2(LOCK_CYCLES + 2);

  logic [RW-1:0] lk_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lk_run <= '0;
    end else if (lockout) begin
      lk_run <= lk_run + 1'b1;
    end else begin
      lk_run <= '0;
    end
  end

  AST_ALLOW_FROM_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    write_allow |-> $past(load_valid && !lockout)); // R8

  AST_LOCK_ONLY_PROT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lockout) |-> prot_on); // R5

  AST_LOCK_NOT_OVER: assert property (@(posedge clk) disable iff (!rst_n)
    lockout |-> (lk_run < RW'(LOCK_CYCLES))); // R5

  AST_LOCK_FULL_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lockout) |-> (lk_run == RW'(LOCK_CYCLES))); // R5

  AST_PROT_HELD_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    lockout |=> $stable(prot_on)); // R8

  AST_PROT_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(prot_on) |-> $past(load_valid)); // R10

  AST_ALLOW_XOR_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    write_allow |-> !$rose(lockout)); // R7

endmodule

bind swp_guard swp_guard_chk #(
  .LOCK_CYCLES (LOCK_CYCLES)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .load_valid  (load_valid),
  .write_allow (write_allow),
  .prot_on     (prot_on),
  .lockout     (lockout)
);

// File: tb/tb_swp_guard.sv
`timescale 1ns/1ps
module tb_swp_guard;

  localparam int LOCK = 16;
  localparam int NV   = 26;

  logic        clk;
  logic        rst_n;
  logic        load_valid;
  logic [14:0] load_addr;
  logic [7:0]  load_data;
  logic        write_allow;
  logic        prot_on;
  logic        lockout;

  int checks;
  int fails;
  bit done;

  swp_guard #(
    .ADDR_W      (15),
    .DATA_W      (8),
    .LOCK_CYCLES (LOCK)
  ) dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_valid  (load_valid),
    .load_addr   (load_addr),
    .load_data   (load_data),
    .write_allow (write_allow),
    .prot_on     (prot_on),
    .lockout     (lockout)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // {valid, addr, data, exp allow, exp prot, exp lock}
  localparam logic [26:0] VEC [0:NV-1] = '{
    {1'b1, 15'h0100, 8'h12, 3'b100},   // R2 plain load unprotected
    {1'b1, 15'h5555, 8'hAA, 3'b000},   // R3
    {1'b1, 15'h2AAA, 8'h55, 3'b000},   // R3
    {1'b1, 15'h5555, 8'hA0, 3'b010},   // R3 prefix arms protection
    {1'b1, 15'h0200, 8'h34, 3'b110},   // R4
    {1'b0, 15'h0000, 8'h00, 3'b010},   // R10 idle
    {1'b1, 15'h5555, 8'hAA, 3'b010},   // R3
    {1'b1, 15'h2AAA, 8'h55, 3'b010},   // R3
    {1'b1, 15'h5555, 8'hA0, 3'b010},   // R3
    {1'b1, 15'h0201, 8'h56, 3'b110},   // R4 protected write
    {1'b1, 15'h5555, 8'hAA, 3'b010},   // R6
    {1'b1, 15'h2AAA, 8'h55, 3'b010},   // R6
    {1'b1, 15'h5555, 8'h80, 3'b010},   // R6
    {1'b1, 15'h5555, 8'hAA, 3'b010},   // R6
    {1'b1, 15'h2AAA, 8'h55, 3'b010},   // R6
    {1'b1, 15'h5555, 8'h20, 3'b000},   // R6 disarmed
    {1'b1, 15'h0300, 8'h78, 3'b100},   // R2
    {1'b1, 15'h5555, 8'hAA, 3'b000},   // R7
    {1'b1, 15'h2AAA, 8'h55, 3'b000},   // R7
    {1'b1, 15'h5555, 8'hAA, 3'b100},   // R7 mismatch is a plain load
    {1'b1, 15'h2AAA, 8'h55, 3'b100},   // R7 no restart
    {1'b1, 15'h5555, 8'hA0, 3'b100},   // R7 no arm
    {1'b1, 15'h5555, 8'hAA, 3'b000},   // R3
    {1'b1, 15'h2AAA, 8'h55, 3'b000},   // R3
    {1'b1, 15'h5555, 8'hA0, 3'b010},   // R3
    {1'b1, 15'h0400, 8'h9A, 3'b110}    // R4
  };

  // Loads fed during lockout: disarm command then unlock prefix.
  localparam logic [22:0] LK_STIM [0:8] = '{
    {15'h5555, 8'hAA}, {15'h2AAA, 8'h55}, {15'h5555, 8'h80},
    {15'h5555, 8'hAA}, {15'h2AAA, 8'h55}, {15'h5555, 8'h20},
    {15'h5555, 8'hAA}, {15'h2AAA, 8'h55}, {15'h5555, 8'hA0}
  };

  task automatic check3(input logic [2:0] exp, input string tag);
    checks++;
    if ({write_allow, prot_on, lockout} !== exp) begin
      fails++;
      $display("FAIL %s: allow/prot/lock got %b expected %b", tag,
               {write_allow, prot_on, lockout}, exp);
    end
  endtask

  task automatic step(input logic v, input logic [14:0] a, input logic [7:0] d,
                      input logic [2:0] exp, input string tag);
    load_valid = v;
    load_addr  = a;
    load_data  = d;
    @(posedge clk);
    @(negedge clk);
    load_valid = 1'b0;
    check3(exp, tag);
  endtask

  task automatic wait_unlock();
    for (int k = 0; k < 4 * LOCK && lockout; k++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    #1;
    check3(3'b000, "R1 during reset");
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check3(3'b000, "R1 after release");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, got hang expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    checks     = 0;
    fails      = 0;
    done       = 1'b0;
    load_valid = 1'b0;
    load_addr  = '0;
    load_data  = '0;
    @(negedge clk);
    do_reset();

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][26], VEC[i][25:11], VEC[i][10:3], VEC[i][2:0],
           $sformatf("vector %0d (R2-group table)", i));
    end

    // R9: second load after an authorised one is refused; R5 lockout length
    step(1'b1, 15'h0500, 8'hBB, 3'b011, "R9 second load refused");
    begin
      int n;
      n = 1;
      for (int k = 0; k < 4 * LOCK && lockout; k++) begin
        if (k < 9) begin
          load_valid = 1'b1;
          {load_addr, load_data} = LK_STIM[k];
        end
        @(posedge clk);
        @(negedge clk);
        load_valid = 1'b0;
        checks++;
        if (write_allow !== 1'b0 || prot_on !== 1'b1) begin
          fails++;
          $display("FAIL R8 load in lockout: allow/prot got %b%b expected 01",
                   write_allow, prot_on);
        end
        if (lockout) n++;
      end
      checks++;
      if (n != LOCK) begin
        fails++;
        $display("FAIL R5 lockout length: got %0d expected %0d", n, LOCK);
      end
    end
    step(1'b1, 15'h0600, 8'hCC, 3'b011, "R8 prefix inside lockout not kept");
    wait_unlock();
    check3(3'b010, "R5 lockout ends, protection held");

    // R7: mismatch inside prefix while protected
    step(1'b1, 15'h5555, 8'hAA, 3'b010, "R7 prefix start");
    step(1'b1, 15'h2AAA, 8'h55, 3'b010, "R7 prefix second");
    step(1'b1, 15'h0700, 8'h11, 3'b011, "R7 protected mismatch locks");
    wait_unlock();

    // R7: broken disarm command keeps protection
    step(1'b1, 15'h5555, 8'hAA, 3'b010, "R7 disarm 1");
    step(1'b1, 15'h2AAA, 8'h55, 3'b010, "R7 disarm 2");
    step(1'b1, 15'h5555, 8'h80, 3'b010, "R7 disarm 3");
    step(1'b1, 15'h5555, 8'hAA, 3'b010, "R7 disarm 4");
    step(1'b1, 15'h2AAA, 8'h12, 3'b011, "R7 disarm broken");
    wait_unlock();
    check3(3'b010, "R7 protection kept");

    // R1: reset in the middle of a prefix
    step(1'b1, 15'h5555, 8'hAA, 3'b010, "R1 pre-reset 1");
    step(1'b1, 15'h2AAA, 8'h55, 3'b010, "R1 pre-reset 2");
    do_reset();
    step(1'b1, 15'h5555, 8'hA0, 3'b100, "R1 matcher cleared by reset");
    step(1'b0, 15'h0000, 8'h00, 3'b000, "R2 pulse is one cycle");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule